// File: doc/BRIEF.md
# Synchronous Receive Character Aligner

This block sits on the receive side of a synchronous serial link and finds where characters begin in a bit stream that has no framing of its own. It samples the serial input on each rising edge of the receive clock, shifts it into a window one character wide, and looks for a programmed alignment pattern. The pattern is either one character or two characters sent back to back. Once the pattern is found, the block stops searching. From then on it cuts the stream into fixed-width characters and hands each one out with a one-cycle valid strobe.

Two ways of finding alignment are supported. In internal mode the block compares the window against the pattern itself and raises a sync flag, which is driven out on the sync-detect pin. That flag serves as a status bit and as an interrupt request, and a status read clears it. In external mode the sync-detect pin turns into an input. Circuitry outside the block decides where alignment lies and drives the pin high; character assembly then starts with the next bit. A search command puts the block back into searching at any time, and reset does the same.

Top module: `sync_hunt`

## Requirements
- R1: While reset is applied and on release, the block is searching, `syndet_out` is 0 and `char_valid` is 0.
- R2: In internal mode with a single-character pattern, `syndet_out` goes to 1 after the edge that samples the last bit of a window equal to `sync_a`. Bits are sampled on the rising edge of `rxc` and arrive least significant bit first.
- R3: While searching, the window is compared on every sampled bit, so the pattern is found at any bit offset in the stream.
- R4: After reset or a search command, a match is only possible once CW fresh bits have been sampled since then.
- R5: With `dual_sync` at 1, a match on `sync_a` alone does not set the flag. The flag is set only when the next CW bits, taken as one character, equal `sync_b`.
- R6: With `dual_sync` at 1, if the character after `sync_a` is not `sync_b`, the flag stays 0. Searching then resumes with the following bit.
- R7: Once aligned, every CW sampled bits give one `char_valid` pulse of one cycle, with the character on `char_data` least significant bit first. The first character starts with the bit after the last pattern bit. Pattern values inside the data are not matched again.
- R8: `status_rd` clears the sync flag. If the flag is set on the same edge as a read, the set wins.
- R9: `hunt_cmd` stops character output at once. The bit sampled on that edge is discarded, and the block goes back to searching.
- R10: In external mode `syndet_oe` is 0 and `syndet_out` is 0. In internal mode `syndet_oe` is 1. In external mode, `syndet_in` sampled high while searching starts character assembly with the next bit.
- R11: In external mode the pattern registers are ignored: patterns on `rxd` produce no flag and no characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rxc | input | 1 | Receive clock; `rxd` is sampled on its rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| ext_sync | input | 1 | 1 selects external alignment, 0 selects internal pattern matching |
| dual_sync | input | 1 | 1 requires a two-character pattern, 0 a single character |
| sync_a | input | CW | First (or only) pattern character |
| sync_b | input | CW | Second pattern character |
| rxd | input | 1 | Serial data in |
| hunt_cmd | input | 1 | Restart searching |
| status_rd | input | 1 | Status read strobe; clears the sync flag |
| syndet_in | input | 1 | External alignment input, used in external mode |
| syndet_out | output | 1 | Sync flag, driven in internal mode |
| syndet_oe | output | 1 | Output enable for the sync-detect pin |
| char_data | output | CW | Last assembled character |
| char_valid | output | 1 | One-cycle strobe for a new character |

## Verification
A run of all-zero bits against a zero pattern sets the flag only on the CW-th bit, which separates a guarded window from one that matches stale reset contents. A single-character pattern placed after three idle bits shows that the match is found at an odd offset and not one bit early. Data characters that include the pattern value show fixed framing with no re-match. For the two-character pattern, the first character followed by an all-ones character is compared against a correct pair, which tells apart "first character only", "wrong second character" and a real match. The correct pair is sent with a status read on its last bit, which also exercises set-over-clear priority. In external mode, pattern bits without the pin give no output, and a single high on the pin aligns the next character.

// File: rtl/sync_hunt.sv
module sync_hunt #(
  parameter int CW = 8
) (
  input  logic          rxc,
  input  logic          rst,
  input  logic          ext_sync,
  input  logic          dual_sync,
  input  logic [CW-1:0] sync_a,
  input  logic [CW-1:0] sync_b,
  input  logic          rxd,
  input  logic          hunt_cmd,
  input  logic          status_rd,
  input  logic          syndet_in,
  output logic          syndet_out,
  output logic          syndet_oe,
  output logic [CW-1:0] char_data,
  output logic          char_valid
);
  localparam int FW = $clog2(CW + 1);
  localparam int BW = (CW > 2) ? $clog2(CW) : 1;

  typedef enum logic [1:0] {S_HUNT, S_SECOND, S_LOCK} st_t;

  st_t           st;
  logic [CW-2:0] sh;
  logic [FW-1:0] fill;
  logic [BW-1:0] cnt;
  logic          flag;

  wire [CW-1:0] win = {rxd, sh};
  wire full     = fill >= FW'(CW - 1);
  wire last     = cnt == BW'(CW - 1);
  wire hit_a    = !ext_sync && st == S_HUNT && full && win == sync_a;
  wire hit_b    = !ext_sync && st == S_SECOND && last && win == sync_b;
  wire sync_hit = (hit_a && !dual_sync) || hit_b;
  wire start    = ext_sync ? (st == S_HUNT && syndet_in) : hit_a;
  wire locked   = st == S_LOCK;
  wire in_second = st == S_SECOND;

  assign syndet_out = flag & ~ext_sync;
  assign syndet_oe  = ~ext_sync;

  always_ff @(posedge rxc or posedge rst) begin
    if (rst) begin
      st   <= S_HUNT;
      sh   <= '0;
      fill <= '0;
      cnt  <= '0;
    end else if (hunt_cmd) begin
      st   <= S_HUNT;
      fill <= '0;
      cnt  <= '0;
    end else begin
      sh <= win[CW-1:1];
      if (!full) fill <= fill + 1'b1;
      case (st)
        S_HUNT: begin
          cnt <= '0;
          if (start) st <= (ext_sync || !dual_sync) ? S_LOCK : S_SECOND;
        end
        S_SECOND: begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (last) st <= hit_b ? S_LOCK : S_HUNT;
        end
        default: cnt <= last ? '0 : cnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge rxc or posedge rst) begin
    if (rst) flag <= 1'b0;
    else if (sync_hit && !hunt_cmd) flag <= 1'b1;
    else if (status_rd) flag <= 1'b0;
  end

  always_ff @(posedge rxc or posedge rst) begin
    if (rst) begin
      char_valid <= 1'b0;
      char_data  <= '0;
    end else begin
      char_valid <= !hunt_cmd && locked && last;
      if (!hunt_cmd && locked && last) char_data <= win;
    end
  end
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
  input logic rxc,
  input logic rst,
  input logic ext_sync,
  input logic dual_sync,
  input logic hunt_cmd,
  input logic status_rd,
  input logic syndet_out,
  input logic char_valid,
  input logic sync_hit,
  input logic locked,
  input logic in_second
);
  a_r1_reset_quiet: assert property (@(posedge rxc)
    rst |=> !syndet_out && !char_valid);

  a_r7_char_only_locked: assert property (@(posedge rxc) disable iff (rst)
    char_valid |-> $past(locked));

  a_r8_read_clears: assert property (@(posedge rxc) disable iff (rst)
    status_rd && !sync_hit |=> !syndet_out);

  a_r9_hunt_stops: assert property (@(posedge rxc) disable iff (rst)
    hunt_cmd |=> !char_valid && !locked);

  a_r5_second_needed: assert property (@(posedge rxc) disable iff (rst)
    $rose(syndet_out) && dual_sync && $past(dual_sync) && !$past(ext_sync)
      |-> $past(in_second));
endmodule

bind sync_hunt sync_hunt_chk u_chk (
  .rxc(rxc), .rst(rst), .ext_sync(ext_sync), .dual_sync(dual_sync),
  .hunt_cmd(hunt_cmd), .status_rd(status_rd), .syndet_out(syndet_out),
  .char_valid(char_valid), .sync_hit(sync_hit), .locked(locked),
  .in_second(in_second)
);

// File: tb/sync_hunt_test.sv
module sync_hunt_test;
  localparam int CW = 8;

  logic rxc = 0, rst = 1, ext_sync = 0, dual_sync = 0, rxd = 1;
  logic hunt_cmd = 0, status_rd = 0, syndet_in = 0;
  logic [CW-1:0] sync_a = 8'h16, sync_b = 8'h68;
  logic syndet_out, syndet_oe, char_valid;
  logic [CW-1:0] char_data;
  int checks = 0, errors = 0;

  sync_hunt #(.CW(CW)) uut (
    .rxc(rxc), .rst(rst), .ext_sync(ext_sync), .dual_sync(dual_sync),
    .sync_a(sync_a), .sync_b(sync_b), .rxd(rxd), .hunt_cmd(hunt_cmd),
    .status_rd(status_rd), .syndet_in(syndet_in), .syndet_out(syndet_out),
    .syndet_oe(syndet_oe), .char_data(char_data), .char_valid(char_valid)
  );

  always #4 rxc = ~rxc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; rxd = 1; hunt_cmd = 0; status_rd = 0; syndet_in = 0;
    @(posedge rxc); @(posedge rxc); @(negedge rxc);
    rst = 0;
  endtask

  task automatic bit_in(input logic b);
    rxd = b;
    @(posedge rxc); @(negedge rxc);
  endtask

  task automatic send_char(input logic [CW-1:0] v);
    for (int i = 0; i < CW; i++) bit_in(v[i]);
  endtask

  task automatic t_reset();
    ext_sync = 0; dual_sync = 0;
    rst = 1; @(posedge rxc); @(negedge rxc);
    chk(syndet_out == 0, "R1 flag in reset", syndet_out, 0);
    chk(char_valid == 0, "R1 valid in reset", char_valid, 0);
    do_reset();
    chk(syndet_out == 0 && char_valid == 0, "R1 after release", {syndet_out, char_valid}, 0);
    chk(syndet_oe == 1, "R10 oe internal", syndet_oe, 1);
  endtask

  task automatic t_fill();
    ext_sync = 0; dual_sync = 0; sync_a = 8'h00;
    do_reset();
    for (int i = 0; i < CW - 1; i++) bit_in(1'b0);
    chk(syndet_out == 0, "R4 no match before full window", syndet_out, 0);
    bit_in(1'b0);
    chk(syndet_out == 1, "R4 match on full window", syndet_out, 1);
  endtask

  task automatic t_single();
    logic [CW-1:0] p = 8'h16;
    ext_sync = 0; dual_sync = 0; sync_a = p;
    do_reset();
    bit_in(1); bit_in(1); bit_in(1);
    for (int i = 0; i < CW - 1; i++) bit_in(p[i]);
    chk(syndet_out == 0, "R3 no early match", syndet_out, 0);
    bit_in(p[CW-1]);
    chk(syndet_out == 1, "R2 single pattern found at odd offset", syndet_out, 1);
    send_char(8'hA5);
    chk(char_valid == 1, "R7 first char strobe", char_valid, 1);
    chk(char_data == 8'hA5, "R7 first char data", char_data, 8'hA5);
    send_char(8'h16);
    chk(char_valid == 1 && char_data == 8'h16, "R7 pattern value as data", char_data, 8'h16);
    status_rd = 1; bit_in(1); status_rd = 0;
    chk(syndet_out == 0, "R8 read clears flag", syndet_out, 0);
    chk(char_valid == 0, "R7 strobe lasts one cycle", char_valid, 0);
    hunt_cmd = 1; bit_in(1); hunt_cmd = 0;
    send_char(8'h3C);
    chk(char_valid == 0, "R9 no chars after hunt", char_valid, 0);
    chk(syndet_out == 0, "R9 no flag from data after hunt", syndet_out, 0);
  endtask

  task automatic t_dual();
    logic [CW-1:0] b = 8'h68;
    ext_sync = 0; dual_sync = 1; sync_a = 8'h16; sync_b = b;
    do_reset();
    bit_in(1); bit_in(1);
    send_char(8'h16);
    chk(syndet_out == 0, "R5 first char alone", syndet_out, 0);
    send_char(8'hFF);
    chk(syndet_out == 0 && char_valid == 0, "R6 wrong second char", syndet_out, 0);
    send_char(8'h16);
    chk(syndet_out == 0, "R6 hunt resumed, first char again", syndet_out, 0);
    for (int i = 0; i < CW - 1; i++) bit_in(b[i]);
    status_rd = 1; bit_in(b[CW-1]); status_rd = 0;
    chk(syndet_out == 1, "R5 R8 pair found, set beats read", syndet_out, 1);
    send_char(8'hC3);
    chk(char_valid == 1 && char_data == 8'hC3, "R7 char after pair", char_data, 8'hC3);
  endtask

  task automatic t_ext();
    ext_sync = 1; dual_sync = 0; sync_a = 8'h16;
    do_reset();
    chk(syndet_oe == 0, "R10 oe external", syndet_oe, 0);
    send_char(8'h16);
    send_char(8'h16);
    chk(syndet_out == 0, "R11 no flag in external mode", syndet_out, 0);
    chk(char_valid == 0, "R11 no chars without pin", char_valid, 0);
    syndet_in = 1; bit_in(1); syndet_in = 0;
    send_char(8'h5A);
    chk(char_valid == 1, "R10 pin starts assembly", char_valid, 1);
    chk(char_data == 8'h5A, "R10 char after pin", char_data, 8'h5A);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_single();
    t_dual();
    t_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule